// File: doc/BRIEF.md
# Burst Ready Generator for a Cache Tag Lookup

This block decides, beside a tag comparator, whether a secondary-cache access may return data at once. It produces an active-low ready signal that the processor bus sees as a burst-ready indication. The raw tag comparison result and the addressed entry's stored valid and write-through bits arrive as inputs; the block combines them with the processor's write/read direction, a force-high override, a clocked external ready input and the tag/status write enables, and produces ready together with an output-drive enable.

All decisions are combinational except the external ready input, which is captured on each rising clock edge and acts in the cycle after the edge. A status-mode select picks between dedicated use of the status bits, where the valid bit qualifies the hit and a write-through entry holds ready off during processor writes, and generic use, where both stored bits are ignored. When several conditions apply, a fixed priority settles the result.

Top module: `brdy_gen`

## Requirements
- R1: While `out_dis_i` is 1, `rdy_oe_o` is 0 and `rdy_n_o` is 1, whatever the other inputs are.
- R2: With the output enabled, any bit of `wr_en_i` at 1 (bit 0 tag write, bit 1 status write) drives `rdy_n_o` to 1.
- R3: With the output enabled and no write, `force_hi_i` at 1 together with a qualified hit drives `rdy_n_o` to 0 regardless of the external ready input. A qualified hit is `hit_i` at 1 and, in dedicated mode (`generic_mode_i` = 0), also `valid_i` at 1.
- R4: `ext_rdy_n_i` is sampled on each rising clock edge; a sampled 0 drives `rdy_n_o` to 0 during the following cycle unless R1, R2 or R3 applies.
- R5: `force_hi_i` at 1 without a qualified hit drives `rdy_n_o` to 1 unless R1, R2 or R4 applies.
- R6: In dedicated mode an entry with `valid_i` at 0 keeps `rdy_n_o` at 1 when no higher condition applies.
- R7: In dedicated mode an entry with `wthru_i` at 1 keeps `rdy_n_o` at 1 while `cpu_write_i` is 1; with `cpu_write_i` at 0 the compare result is used again.
- R8: In generic mode (`generic_mode_i` = 1) `valid_i` and `wthru_i` have no effect on `rdy_n_o`.
- R9: When no other condition applies, `rdy_n_o` is the inverse of `hit_i`: a hit gives 0, a miss gives 1.
- R10: A synchronous reset (`rst` = 1 at a rising edge) sets the sampled external ready to inactive (1), so a 0 applied during reset does not pull ready low in the first cycle after it.
- R11: `rdy_oe_o` is 1 whenever `out_dis_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the external ready input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Raw tag comparison result, 1 when tags are equal |
| valid_i | input | 1 | Stored valid bit of the addressed entry |
| wthru_i | input | 1 | Stored write-through bit of the addressed entry |
| cpu_write_i | input | 1 | Processor direction, 1 for write, 0 for read |
| force_hi_i | input | 1 | Force-high override for ready |
| ext_rdy_n_i | input | 1 | External active-low ready, synchronous |
| wr_en_i | input | WR_PORTS | Write enables, bit 0 tag array, bit 1 status array |
| generic_mode_i | input | 1 | Status mode select: 0 dedicated, 1 generic |
| out_dis_i | input | 1 | Output disable for ready, active high |
| rdy_n_o | output | 1 | Active-low burst ready |
| rdy_oe_o | output | 1 | 1 when ready is driven |

## Verification
Each row of the priority order is set up on its own and then pitted against the row just below it, for example force-high with a qualified hit against a sampled external ready, or a write against force-high, so that a swapped priority shows as a wrong level. Dedicated and generic mode are run with the same valid and write-through patterns to show that only dedicated mode reacts to them. The write-through hold is tried with the processor direction toggling, and the external input is held low across a reset to tell the reset value of its register apart from the sampled value. A long run of mixed random inputs is then compared every cycle against a behavioural reference.

// File: rtl/brdy_pkg.sv
package brdy_pkg;

    // Which rule decided the ready level, highest priority first
    typedef enum logic [2:0] {
        CAUSE_OFF       = 3'd0,
        CAUSE_WRITE     = 3'd1,
        CAUSE_FORCE_HIT = 3'd2,
        CAUSE_EXT       = 3'd3,
        CAUSE_FORCE     = 3'd4,
        CAUSE_POLICY    = 3'd5,
        CAUSE_HIT       = 3'd6,
        CAUSE_MISS      = 3'd7
    } rdy_cause_e;

    // Conditions prepared by the policy stage for the arbiter
    typedef struct packed {
        logic disabled;
        logic write_busy;
        logic force_hi;
        logic qual_hit;
        logic ext_low;
        logic policy_block;
        logic raw_hit;
    } rdy_cond_t;

    // Active-low level driven for each cause
    function automatic logic cause_level(input rdy_cause_e c);
        case (c)
            CAUSE_FORCE_HIT, CAUSE_EXT, CAUSE_HIT: return 1'b0;
            default:                               return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/brdy_ext_sampler.sv
module brdy_ext_sampler #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rdy_n_i,
    output logic ext_low_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_q[g] <= 1'b1;
                end else if (g == 0) begin
                    pipe_q[g] <= ext_rdy_n_i;
                end else begin
                    pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign ext_low_o = ~pipe_q[LAST];

endmodule

// File: rtl/brdy_policy.sv
module brdy_policy
    import brdy_pkg::*;
#(
    parameter int unsigned WR_PORTS = 2
) (
    input  logic                hit_i,
    input  logic                valid_i,
    input  logic                wthru_i,
    input  logic                cpu_write_i,
    input  logic                force_hi_i,
    input  logic [WR_PORTS-1:0] wr_en_i,
    input  logic                generic_mode_i,
    input  logic                out_dis_i,
    input  logic                ext_low_i,
    output rdy_cond_t           cond_o
);
    logic dedicated;
    logic entry_invalid;
    logic wthru_write;

    always_comb begin
        dedicated     = ~generic_mode_i;
        entry_invalid = dedicated & ~valid_i;
        wthru_write   = dedicated & wthru_i & cpu_write_i;

        cond_o.disabled     = out_dis_i;
        cond_o.write_busy   = |wr_en_i;
        cond_o.force_hi     = force_hi_i;
        cond_o.qual_hit     = hit_i & (generic_mode_i | valid_i);
        cond_o.ext_low      = ext_low_i;
        cond_o.policy_block = entry_invalid | wthru_write;
        cond_o.raw_hit      = hit_i;
    end

endmodule

// File: rtl/brdy_arbiter.sv
module brdy_arbiter
    import brdy_pkg::*;
(
    input  rdy_cond_t  cond_i,
    output rdy_cause_e cause_o,
    output logic       rdy_n_o,
    output logic       rdy_oe_o
);
    always_comb begin
        if (cond_i.disabled) begin
            cause_o = CAUSE_OFF;
        end else if (cond_i.write_busy) begin
            cause_o = CAUSE_WRITE;
        end else if (cond_i.force_hi && cond_i.qual_hit) begin
            cause_o = CAUSE_FORCE_HIT;
        end else if (cond_i.ext_low) begin
            cause_o = CAUSE_EXT;
        end else if (cond_i.force_hi) begin
            cause_o = CAUSE_FORCE;
        end else if (cond_i.policy_block) begin
            cause_o = CAUSE_POLICY;
        end else if (cond_i.raw_hit) begin
            cause_o = CAUSE_HIT;
        end else begin
            cause_o = CAUSE_MISS;
        end
        rdy_n_o  = cause_level(cause_o);
        rdy_oe_o = (cause_o != CAUSE_OFF);
    end

endmodule

// File: rtl/brdy_gen.sv
module brdy_gen
    import brdy_pkg::*;
#(
    parameter int unsigned WR_PORTS   = 2,
    parameter int unsigned EXT_STAGES = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_i,
    input  logic                valid_i,
    input  logic                wthru_i,
    input  logic                cpu_write_i,
    input  logic                force_hi_i,
    input  logic                ext_rdy_n_i,
    input  logic [WR_PORTS-1:0] wr_en_i,
    input  logic                generic_mode_i,
    input  logic                out_dis_i,
    output logic                rdy_n_o,
    output logic                rdy_oe_o
);
    logic       ext_low;
    rdy_cond_t  cond;
    rdy_cause_e cause;

    brdy_ext_sampler #(.STAGES(EXT_STAGES)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .ext_rdy_n_i (ext_rdy_n_i),
        .ext_low_o   (ext_low)
    );

    brdy_policy #(.WR_PORTS(WR_PORTS)) u_policy (
        .hit_i          (hit_i),
        .valid_i        (valid_i),
        .wthru_i        (wthru_i),
        .cpu_write_i    (cpu_write_i),
        .force_hi_i     (force_hi_i),
        .wr_en_i        (wr_en_i),
        .generic_mode_i (generic_mode_i),
        .out_dis_i      (out_dis_i),
        .ext_low_i      (ext_low),
        .cond_o         (cond)
    );

    brdy_arbiter u_arbiter (
        .cond_i   (cond),
        .cause_o  (cause),
        .rdy_n_o  (rdy_n_o),
        .rdy_oe_o (rdy_oe_o)
    );

endmodule

// File: rtl/brdy_gen_chk.sv
module brdy_gen_chk #(
    parameter int unsigned WR_PORTS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                hit_i,
    input logic                valid_i,
    input logic                force_hi_i,
    input logic                ext_rdy_n_i,
    input logic [WR_PORTS-1:0] wr_en_i,
    input logic                generic_mode_i,
    input logic                out_dis_i,
    input logic                rdy_n_o,
    input logic                rdy_oe_o
);
    logic live;
    logic qhit;

    assign live = !out_dis_i && (wr_en_i == '0);
    assign qhit = hit_i && (generic_mode_i || valid_i);

    // R1
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        out_dis_i |-> (!rdy_oe_o && rdy_n_o));

    // R11
    assert_drive_on_R11: assert property (@(posedge clk) disable iff (rst)
        !out_dis_i |-> rdy_oe_o);

    // R2
    assert_write_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!out_dis_i && (wr_en_i != '0)) |-> rdy_n_o);

    // R3
    assert_force_hit_low_R3: assert property (@(posedge clk) disable iff (rst)
        (live && force_hi_i && qhit) |-> !rdy_n_o);

    // R4 and R10: a sampled low (outside reset) acts one cycle later
    assert_ext_low_R4: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(rst) && !$past(ext_rdy_n_i)) |-> !rdy_n_o);

    // R6
    assert_invalid_high_R6: assert property (@(posedge clk) disable iff (rst)
        (live && !generic_mode_i && !valid_i && !force_hi_i
         && ($past(rst) || $past(ext_rdy_n_i))) |-> rdy_n_o);

endmodule

bind brdy_gen brdy_gen_chk #(.WR_PORTS(WR_PORTS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hit_i          (hit_i),
    .valid_i        (valid_i),
    .force_hi_i     (force_hi_i),
    .ext_rdy_n_i    (ext_rdy_n_i),
    .wr_en_i        (wr_en_i),
    .generic_mode_i (generic_mode_i),
    .out_dis_i      (out_dis_i),
    .rdy_n_o        (rdy_n_o),
    .rdy_oe_o       (rdy_oe_o)
);

// File: tb/brdy_gen_tb.sv
module brdy_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_i = 0, valid_i = 0, wthru_i = 0, cpu_write_i = 0;
    logic       force_hi_i = 0, ext_rdy_n_i = 1, generic_mode_i = 0, out_dis_i = 0;
    logic [1:0] wr_en_i = 2'b00;
    logic       rdy_n_o, rdy_oe_o;

    int checks   = 0;
    int failures = 0;
    int m_ext    = 1;   // model of the sampled external ready (1 = inactive)
    bit done     = 0;

    always #2.5 clk = ~clk;

    brdy_gen dut_i (
        .clk(clk), .rst(rst), .hit_i(hit_i), .valid_i(valid_i), .wthru_i(wthru_i),
        .cpu_write_i(cpu_write_i), .force_hi_i(force_hi_i), .ext_rdy_n_i(ext_rdy_n_i),
        .wr_en_i(wr_en_i), .generic_mode_i(generic_mode_i), .out_dis_i(out_dis_i),
        .rdy_n_o(rdy_n_o), .rdy_oe_o(rdy_oe_o)
    );

    // Behavioural reference: returns expected level, names the deciding requirement
    function automatic int ref_level(output string req);
        int qual;
        qual = hit_i && (generic_mode_i || valid_i);
        if (out_dis_i)                      begin req = "R1";  return 1; end
        if (wr_en_i != 0)                   begin req = "R2";  return 1; end
        if (force_hi_i && qual)             begin req = "R3";  return 0; end
        if (m_ext == 0)                     begin req = "R4";  return 0; end
        if (force_hi_i)                     begin req = "R5";  return 1; end
        if (!generic_mode_i && !valid_i)    begin req = "R6";  return 1; end
        if (!generic_mode_i && wthru_i && cpu_write_i) begin req = "R7"; return 1; end
        req = generic_mode_i ? "R8" : "R9";
        return hit_i ? 0 : 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Apply one input set at the falling edge, check mid-cycle, then advance the model
    task automatic step(input logic h, v, w, cw, f, e, input logic [1:0] we,
                        input logic g, d, r, input bit chk);
        string req;
        int    exp;
        @(negedge clk);
        hit_i = h; valid_i = v; wthru_i = w; cpu_write_i = cw; force_hi_i = f;
        ext_rdy_n_i = e; wr_en_i = we; generic_mode_i = g; out_dis_i = d; rst = r;
        #1;
        if (chk && !r) begin
            exp = ref_level(req);
            check(req, int'(rdy_n_o), exp);
            check("R11", int'(rdy_oe_o), out_dis_i ? 0 : 1);
        end
        @(posedge clk);
        m_ext = r ? 1 : int'(e);
    endtask

    initial begin
        // reset, with the external input held low to exercise R10
        for (int i = 0; i < 3; i++) step(0,0,0,0,0,0,2'b00,0,0,1,0);
        // R10: first cycle after reset, ready must follow compare (miss -> 1)
        step(0,1,0,0,0,1,2'b00,0,0,0,1);
        step(1,1,0,0,0,1,2'b00,0,0,0,1);           // R9 hit -> 0
        step(0,1,0,0,0,1,2'b00,0,0,0,1);           // R9 miss -> 1
        step(1,1,0,0,0,1,2'b00,0,1,0,1);           // R1 disabled
        step(1,1,0,0,1,0,2'b00,0,1,0,1);           // R1 over force-hit
        step(1,1,0,0,1,1,2'b01,0,0,0,1);           // R2 tag write over R3 (ext low sampled)
        step(1,1,0,0,0,1,2'b10,0,0,0,1);           // R2 status write over hit
        step(1,1,0,0,1,1,2'b00,0,0,0,1);           // R3 force with valid hit
        step(1,0,0,0,1,0,2'b00,0,0,0,1);           // R5 force, unqualified hit
        step(1,0,0,0,1,1,2'b00,0,0,0,1);           // R4 sampled low beats force
        step(1,0,0,0,1,1,2'b00,1,0,0,1);           // R3 generic: hit qualifies
        step(1,0,0,0,0,1,2'b00,0,0,0,1);           // R6 invalid keeps high
        step(1,0,1,1,0,1,2'b00,1,0,0,1);           // R8 generic ignores both bits
        step(1,1,1,1,0,1,2'b00,0,0,0,1);           // R7 write-through write -> 1
        step(1,1,1,0,0,1,2'b00,0,0,0,1);           // R7 read again -> compare 0
        step(1,1,1,1,0,0,2'b00,0,0,0,1);           // R7 hold
        step(0,1,1,1,0,1,2'b00,0,0,0,1);           // R4 sampled low beats R7
        step(0,1,0,0,0,1,2'b00,0,0,0,1);           // R9 miss after ext release
        // mid-run reset with external low: R10
        step(0,1,0,0,0,0,2'b00,0,0,1,0);
        step(0,1,0,0,0,1,2'b00,0,0,0,1);
        // mixed random traffic, compared every cycle
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            step(r[0], r[1] | r[2], r[3], r[4], r[5] & r[6], r[7] | r[8],
                 {r[9] & r[10] & r[11], r[12] & r[13] & r[14]},
                 r[15] & r[2], (r[5:0] == 6'd7), 1'b0, 1'b1);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule